// File: doc/BRIEF.md
# I2C Serial EEPROM Target Controller

This block is an I2C target that fronts a 256-byte array held in registers. Both bus lines are sampled on the system clock. SDA is driven only through an open-drain style enable, which pulls the line low while it is asserted. The block finds START and STOP conditions and checks the 7-bit device address. It then carries out single-byte writes, reads from the current address, and random reads. A read can continue through further bytes for as long as the controller acknowledges them.

A STOP that ends a completed write starts a fixed programming interval, which is counted in system clocks. For that whole interval `busy` is high and the block is invisible on the bus: it acknowledges nothing, including its own address. An internal 8-bit pointer tracks the position in the array. A word-address byte loads it, and it advances after every byte that is transferred.

Top module: `i2c_ee_target`

## Requirements
- R1: A START is SDA falling while SCL is high. A STOP is SDA rising while SCL is high. A START in any state, including in the middle of a byte, clears the bit count and begins reception of a new address byte.
- R2: The first byte after a START is acknowledged only when its seven most significant bits equal DEV_ADDR (default 1010000 binary). Its least significant bit, the last one sent, selects the direction: 1 is read and 0 is write. On a mismatch the block does not acknowledge and ignores the bus until the next START.
- R3: For a write, the block acknowledges the address byte, the word address and one data byte. Each acknowledge pulls SDA low during the ninth SCL clock. The word address is loaded into the pointer, and the data byte is stored at that location.
- R4: `busy` is low after reset. A STOP that follows an acknowledged data byte raises `busy`. A STOP that ends a transaction without such a byte leaves `busy` low.
- R5: While `busy` is high, `sda_oe` stays low, so no access is acknowledged, including one that carries the block's own address.
- R6: `busy` stays high for exactly PROG_CYCLES system clocks. After that the block answers the bus again.
- R7: Read data is sent most significant bit first. SDA changes only while SCL is low. The block releases SDA for the ninth clock and samples the controller's acknowledge there.
- R8: The pointer increments after every byte read or written and wraps from 255 to 0.
- R9: If the controller acknowledges a read byte, the block sends the byte at the next pointer value. If the controller does not acknowledge, the block releases SDA and drives nothing until the next START or STOP.
- R10: A read that follows a START returns the byte at the current pointer. A write of the word address followed by a repeated START and a read returns the byte at that address, and this sequence does not start programming.
- R11: Only one data byte is accepted per write. Further data bytes are neither acknowledged nor stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line (the resolved wired value) |
| sda_oe | output | 1 | When high, the block pulls SDA low |
| busy | output | 1 | High during the internal programming interval |

## Verification
Two functions can meet in the same cycle: the STOP that ends a write, which starts the programming interval, and a new START with an address byte that follows that STOP at once. The bench sends a valid address byte immediately after the STOP of a write. A correct block gives no acknowledge there, and the length of the `busy` pulse must still come out at exactly PROG_CYCLES clocks. A second meeting point is the pointer wrap happening while a read continues. A read that starts at address 255 and is acknowledged must deliver the byte at address 0 next.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_WADR,
    ST_WADR_ACK,
    ST_WDAT,
    ST_WDAT_ACK,
    ST_RDAT,
    ST_RD_ACK,
    ST_HOLD
  } ee_state_e;
endpackage

// File: rtl/i2c_ee_sync.sv
module i2c_ee_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic rst_sn,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [1:0] rst_ff;
  logic [2:0] scl_ff;
  logic [2:0] sda_ff;

  // reset: asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_ff <= 2'b00;
    else        rst_ff <= {rst_ff[0], 1'b1};
  end
  assign rst_sn = rst_ff[1];

  // two synchroniser flops plus one history flop for each line
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= 3'b111;
      sda_ff <= 3'b111;
    end else begin
      scl_ff <= {scl_ff[1:0], scl_i};
      sda_ff <= {sda_ff[1:0], sda_i};
    end
  end

  assign scl_lvl   = scl_ff[1];
  assign sda_lvl   = sda_ff[1];
  assign scl_rise  = scl_ff[1] & ~scl_ff[2];
  assign scl_fall  = ~scl_ff[1] & scl_ff[2];
  assign start_det = scl_ff[1] & scl_ff[2] & sda_ff[2] & ~sda_ff[1];
  assign stop_det  = scl_ff[1] & scl_ff[2] & ~sda_ff[2] & sda_ff[1];
endmodule

// File: rtl/i2c_ee_prog.sv
module i2c_ee_prog #(
  parameter int PROG_CYCLES = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(PROG_CYCLES + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign busy   = (cnt_q != '0);
  assign cnt_en = busy | start;

  always_comb begin
    cnt_d = cnt_q;
    if (busy)       cnt_d = cnt_q - CW'(1);
    else if (start) cnt_d = CW'(PROG_CYCLES);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/i2c_ee_mem.sv
module i2c_ee_mem #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/i2c_ee_fsm.sv
module i2c_ee_fsm
  import i2c_ee_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1010000,
  parameter int         AW       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          sda_lvl,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic          busy,
  input  logic [7:0]    mem_rdata,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [7:0]    mem_wdata,
  output logic [AW-1:0] ptr,
  output logic          ptr_inc,
  output logic          ptr_load,
  output logic          prog_start,
  output logic          sda_oe
);
  ee_state_e     state_q, state_d;
  logic [2:0]    bcnt_q, bcnt_d;
  logic          full_q, full_d;
  logic [7:0]    shreg_q, shreg_d;
  logic [AW-1:0] ptr_q, ptr_d;
  logic          rw_q, rw_d;
  logic          ack_q, ack_d;
  logic          mack_q, mack_d;
  logic          wpend_q, wpend_d;

  always_comb begin
    state_d    = state_q;
    bcnt_d     = bcnt_q;
    full_d     = full_q;
    shreg_d    = shreg_q;
    rw_d       = rw_q;
    ack_d      = ack_q;
    mack_d     = mack_q;
    wpend_d    = wpend_q;
    mem_we     = 1'b0;
    ptr_inc    = 1'b0;
    ptr_load   = 1'b0;
    prog_start = 1'b0;

    if (start_det) begin
      ack_d  = 1'b0;
      bcnt_d = '0;
      full_d = 1'b0;
      state_d = busy ? ST_IDLE : ST_DEV;
    end else if (stop_det) begin
      state_d    = ST_IDLE;
      ack_d      = 1'b0;
      bcnt_d     = '0;
      full_d     = 1'b0;
      prog_start = wpend_q & ~busy;
      wpend_d    = 1'b0;
    end else begin
      unique case (state_q)
        ST_DEV, ST_WADR, ST_WDAT: begin
          if (scl_rise && !full_q) begin
            shreg_d = {shreg_q[6:0], sda_lvl};
            bcnt_d  = bcnt_q + 3'd1;
            if (bcnt_q == 3'd7) full_d = 1'b1;
          end else if (scl_fall && full_q) begin
            full_d = 1'b0;
            bcnt_d = '0;
            if (state_q == ST_DEV) begin
              if (shreg_q[7:1] == DEV_ADDR) begin
                state_d = ST_DEV_ACK;
                rw_d    = shreg_q[0];
                ack_d   = 1'b1;
              end else begin
                state_d = ST_HOLD;
              end
            end else if (state_q == ST_WADR) begin
              state_d  = ST_WADR_ACK;
              ack_d    = 1'b1;
              ptr_load = 1'b1;
            end else begin
              state_d = ST_WDAT_ACK;
              ack_d   = 1'b1;
              mem_we  = 1'b1;
              ptr_inc = 1'b1;
              wpend_d = 1'b1;
            end
          end
        end
        ST_DEV_ACK: begin
          if (scl_fall) begin
            ack_d = 1'b0;
            if (rw_q) begin
              state_d = ST_RDAT;
              shreg_d = mem_rdata;
              bcnt_d  = '0;
            end else begin
              state_d = ST_WADR;
            end
          end
        end
        ST_WADR_ACK: begin
          if (scl_fall) begin
            ack_d   = 1'b0;
            state_d = ST_WDAT;
          end
        end
        ST_WDAT_ACK: begin
          if (scl_fall) begin
            ack_d   = 1'b0;
            state_d = ST_HOLD;
          end
        end
        ST_RDAT: begin
          if (scl_fall) begin
            if (bcnt_q == 3'd7) begin
              state_d = ST_RD_ACK;
              ptr_inc = 1'b1;
            end else begin
              shreg_d = {shreg_q[6:0], 1'b0};
              bcnt_d  = bcnt_q + 3'd1;
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) mack_d = ~sda_lvl;
          else if (scl_fall) begin
            if (mack_q) begin
              state_d = ST_RDAT;
              shreg_d = mem_rdata;
              bcnt_d  = '0;
            end else begin
              state_d = ST_HOLD;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    ptr_d = ptr_q;
    if (ptr_load)     ptr_d = shreg_q[AW-1:0];
    else if (ptr_inc) ptr_d = ptr_q + AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bcnt_q  <= '0;
      full_q  <= 1'b0;
      shreg_q <= '0;
      ptr_q   <= '0;
      rw_q    <= 1'b0;
      ack_q   <= 1'b0;
      mack_q  <= 1'b0;
      wpend_q <= 1'b0;
    end else begin
      state_q <= state_d;
      bcnt_q  <= bcnt_d;
      full_q  <= full_d;
      shreg_q <= shreg_d;
      ptr_q   <= ptr_d;
      rw_q    <= rw_d;
      ack_q   <= ack_d;
      mack_q  <= mack_d;
      wpend_q <= wpend_d;
    end
  end

  assign ptr       = ptr_q;
  assign mem_waddr = ptr_q;
  assign mem_wdata = shreg_q;
  assign sda_oe    = ack_q | ((state_q == ST_RDAT) & ~shreg_q[7]);
endmodule

// File: rtl/i2c_ee_target.sv
module i2c_ee_target #(
  parameter logic [6:0] DEV_ADDR    = 7'b1010000,
  parameter int         AW          = 8,
  parameter int         PROG_CYCLES = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe,
  output logic busy
);
  logic          rst_sn;
  logic          scl_lvl, sda_lvl, scl_rise, scl_fall;
  logic          start_det, stop_det;
  logic          mem_we, ptr_inc, ptr_load, prog_start;
  logic [AW-1:0] mem_waddr, ptr;
  logic [7:0]    mem_wdata, mem_rdata;

  i2c_ee_sync u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .rst_sn    (rst_sn),
    .scl_lvl   (scl_lvl),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_ee_fsm #(.DEV_ADDR(DEV_ADDR), .AW(AW)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_sn),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .sda_lvl    (sda_lvl),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .busy       (busy),
    .mem_rdata  (mem_rdata),
    .mem_we     (mem_we),
    .mem_waddr  (mem_waddr),
    .mem_wdata  (mem_wdata),
    .ptr        (ptr),
    .ptr_inc    (ptr_inc),
    .ptr_load   (ptr_load),
    .prog_start (prog_start),
    .sda_oe     (sda_oe)
  );

  i2c_ee_mem #(.AW(AW), .DW(8)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (ptr),
    .rdata (mem_rdata)
  );

  i2c_ee_prog #(.PROG_CYCLES(PROG_CYCLES)) u_prog (
    .clk   (clk),
    .rst_n (rst_sn),
    .start (prog_start),
    .busy  (busy)
  );
endmodule

// File: rtl/i2c_ee_chk.sv
module i2c_ee_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_lvl,
  input logic          sda_oe,
  input logic          busy,
  input logic          prog_start,
  input logic          stop_det,
  input logic [AW-1:0] ptr,
  input logic          ptr_inc,
  input logic          ptr_load
);
  // R5
  silent_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe);

  // R4
  prog_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> stop_det);

  // R6
  busy_from_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(prog_start));

  // R8
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr == {AW{1'b1}} && ptr_inc && !ptr_load) |=> (ptr == '0));

  // R7
  sda_change_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_lvl);
endmodule

bind i2c_ee_target i2c_ee_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .scl_lvl    (scl_lvl),
  .sda_oe     (sda_oe),
  .busy       (busy),
  .prog_start (prog_start),
  .stop_det   (stop_det),
  .ptr        (ptr),
  .ptr_inc    (ptr_inc),
  .ptr_load   (ptr_load)
);

// File: tb/i2c_ee_target_tb.sv
`timescale 1ns/1ps
module i2c_ee_target_tb;
  localparam int  PROG = 400;
  localparam int  HALF = 10;
  localparam logic [7:0] DEV_W = 8'hA0;
  localparam logic [7:0] DEV_R = 8'hA1;
  // each entry: {word address, data}
  localparam logic [15:0] VEC [7] = '{16'h103C, 16'h11A5, 16'h015E, 16'hFFC3,
                                      16'h0096, 16'h8001, 16'h2177};

  logic clk, rst_n, scl, m_low, sda_oe, busy, sda;
  int   n_chk, n_bad, run_len, last_len, glitch;
  bit   done;

  assign sda = ~(m_low | sda_oe);

  i2c_ee_target #(.PROG_CYCLES(PROG)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .sda_oe(sda_oe), .busy(busy)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (busy) run_len++;
    else if (run_len != 0) begin last_len = run_len; run_len = 0; end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic hp(); repeat (HALF) @(negedge clk); endtask

  task automatic i_start();
    m_low = 1'b0; hp(); scl = 1'b1; hp(); m_low = 1'b1; hp(); scl = 1'b0; hp();
  endtask

  task automatic i_stop();
    m_low = 1'b1; hp(); scl = 1'b1; hp(); m_low = 1'b0; hp();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      m_low = ~b[i]; hp(); scl = 1'b1; hp(); scl = 1'b0;
    end
    m_low = 1'b0; hp(); scl = 1'b1;
    repeat (HALF/2) @(negedge clk);
    acked = ~sda;
    repeat (HALF/2) @(negedge clk);
    scl = 1'b0;
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    logic s0;
    m_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      hp(); scl = 1'b1; s0 = sda;
      repeat (HALF/2) @(negedge clk);
      b[i] = sda;
      repeat (HALF/2) @(negedge clk);
      if (sda !== s0) glitch++;
      scl = 1'b0;
    end
    m_low = give_ack; hp(); scl = 1'b1; hp(); scl = 1'b0;
    repeat (3) @(negedge clk);
    m_low = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    hp();
  endtask

  task automatic rand_read(input logic [7:0] a, input bit cont, output logic [7:0] d);
    bit ak;
    i_start(); send_byte(DEV_W, ak); chk("R10 dev ack", ak, 1);
    send_byte(a, ak); chk("R10 addr ack", ak, 1);
    i_start(); send_byte(DEV_R, ak); chk("R10 read ack", ak, 1);
    recv_byte(cont, d);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    if (!done) begin
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    bit ak;
    logic [7:0] d;
    n_chk = 0; n_bad = 0; run_len = 0; last_len = 0; glitch = 0; done = 0;
    scl = 1'b1; m_low = 1'b0; rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R4 reset busy", busy, 0);
    chk("R5 reset sda_oe", sda_oe, 0);

    // table walk: byte writes
    for (int k = 0; k < 7; k++) begin
      i_start();
      send_byte(DEV_W, ak);        chk("R2 dev ack", ak, 1);
      send_byte(VEC[k][15:8], ak); chk("R3 word addr ack", ak, 1);
      send_byte(VEC[k][7:0], ak);  chk("R3 data ack", ak, 1);
      i_stop();
      chk("R4 busy after write", busy, 1);
      if (k == 0) begin
        // a new access right behind the STOP, during programming
        i_start(); send_byte(DEV_W, ak); chk("R5 no ack while busy", ak, 0);
        i_stop();
      end
      wait_idle();
      chk("R6 busy length", last_len, PROG);
    end
    // table walk: random reads
    for (int k = 0; k < 7; k++) begin
      rand_read(VEC[k][15:8], 1'b0, d); i_stop();
      chk("R10 random read", d, VEC[k][7:0]);
    end
    chk("R4 no busy after reads", busy, 0);
    chk("R7 sda stable while scl high", glitch, 0);

    // sequential continuation across the wrap
    rand_read(8'hFF, 1'b1, d); chk("R9 first byte", d, 8'hC3);
    recv_byte(1'b0, d);        chk("R8 wrap to 0", d, 8'h96);
    // after NACK: clock a byte's worth, block must not drive
    ak = 0;
    for (int i = 0; i < 9; i++) begin
      hp(); scl = 1'b1; hp(); if (sda === 1'b0) ak = 1; scl = 1'b0;
    end
    chk("R9 silent after nack", ak, 0);
    i_stop();

    // current-address read: pointer is now 0x01
    i_start(); send_byte(DEV_R, ak); chk("R10 cur read ack", ak, 1);
    recv_byte(1'b0, d); i_stop();
    chk("R10 current address", d, 8'h5E);

    // wrong device address
    i_start(); send_byte(8'hA2, ak); chk("R2 mismatch nack", ak, 0);
    send_byte(8'h20, ak); chk("R2 ignored after mismatch", ak, 0);
    i_stop(); hp();
    chk("R4 no busy after mismatch", busy, 0);

    // second data byte refused
    i_start(); send_byte(DEV_W, ak); send_byte(8'h20, ak);
    send_byte(8'h11, ak); chk("R11 first data ack", ak, 1);
    send_byte(8'h22, ak); chk("R11 second data nack", ak, 0);
    i_stop(); wait_idle();
    rand_read(8'h21, 1'b0, d); i_stop(); chk("R11 next cell untouched", d, 8'h77);
    rand_read(8'h20, 1'b0, d); i_stop(); chk("R11 first byte stored", d, 8'h11);

    // START mid-byte restarts address reception; pointer now 0x21
    i_start();
    for (int i = 0; i < 3; i++) begin
      m_low = 1'b0; hp(); scl = 1'b1; hp(); scl = 1'b0;
    end
    i_start(); send_byte(DEV_R, ak); chk("R1 ack after restart", ak, 1);
    recv_byte(1'b0, d); i_stop();
    chk("R1 read after restart", d, 8'h77);

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule